// File: doc/BRIEF.md
# USB Device DMA Channel

This block is one DMA channel that carries packet bytes from a USB device endpoint into system memory. The endpoint side offers bytes through a request/acknowledge pair. The channel queues them in a small internal FIFO, and a bus-side request/acknowledge pair empties that FIFO. A 16-bit remaining-byte counter goes down by one on every endpoint byte taken. The transfer closes when the counter runs out, when the endpoint signals a transfer end (only if closing on that event is enabled), or when software disables the channel.

Software writes a control word that carries four things: an enable bit, a load-next-descriptor bit, a close-on-endpoint-end bit and a starting byte count. It reads one 32-bit status word. That word holds the enabled and active bits, three sticky event flags that clear when the word is read, and the live byte count. When the count runs out with load-next set, the channel asks for a new descriptor after its FIFO has drained. A load-done strobe then supplies the next count and restarts the channel.

Top module: `usbdma_chan`

## Requirements
- R1: After a synchronous reset, the status word reads all zeros, and bus_req, desc_req and ep_ack are low.
- R2: Enabling takes one extra cycle. A control write with enable set loads the byte count. The enabled status bit (bit 0) stays 0 in the cycle after that write and reads 1 one cycle later.
- R3: Each endpoint byte accepted (ep_ack high at a clock edge) lowers the byte count by exactly one. The count appears in status bits 31:16, and all unassigned status bits read 0.
- R4: When the count reaches zero, the channel sets the end-of-buffer flag (status bit 5) and accepts no further endpoint bytes. The enabled bit clears once the FIFO is empty.
- R5: A pulse on ep_end while running ends the transfer and sets the end-of-transfer flag (status bit 4), but only if close-on-end is enabled. With close-on-end disabled, ep_end has no effect: the channel stays enabled, the flag stays 0 and the count is unchanged.
- R6: A control write with enable cleared during a transfer stops endpoint acceptance at once. The enabled bit stays 1 while the FIFO drains over the bus side, and it drops in the cycle after the FIFO becomes empty.
- R7: A status read (stat_rd) clears the three sticky flags after that cycle. If a flag's set event coincides with a read, the flag is set afterwards.
- R8: When the count runs out with load-next set, desc_req goes high after the FIFO has drained. On desc_done, the count is reloaded from desc_count, the descriptor-loaded flag (status bit 6) is set and the enabled bit reads 1.
- R9: The active bit (status bit 1) is 1 only while the channel is running with a nonzero count and ep_req high. It is 0 while draining or waiting for a descriptor.
- R10: Bytes leave on bus_data in the order they were accepted. ep_ack stays low while the FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_en | input | 1 | Control: channel enable |
| ctl_ldnext | input | 1 | Control: fetch next descriptor when count runs out |
| ctl_closein | input | 1 | Control: let ep_end close the transfer |
| ctl_count | input | 16 | Control: starting byte count (loaded when enabling from idle) |
| stat_rd | input | 1 | Status read strobe; clears sticky flags |
| stat_rdata | output | 32 | Status word |
| ep_req | input | 1 | Endpoint has a byte to offer |
| ep_data | input | DATA_W | Endpoint byte |
| ep_end | input | 1 | Endpoint-initiated transfer end |
| ep_ack | output | 1 | Byte taken this cycle |
| bus_req | output | 1 | FIFO holds a byte for the bus side |
| bus_data | output | DATA_W | Oldest FIFO byte |
| bus_ack | input | 1 | Bus side takes the byte this cycle |
| desc_req | output | 1 | Next descriptor requested |
| desc_done | input | 1 | Descriptor load-done strobe |
| desc_count | input | 16 | Byte count from the loaded descriptor |

## Verification
The bench builds the channel with a FIFO depth of 2 and the default 8-bit data width. With a depth of 2, the FIFO fills after two accepted bytes. That makes the full-FIFO stall, the drain after a disable and the drain before a descriptor request all reachable with counts of only a few bytes. Short counts also let the bench follow each decrement and the end-of-buffer event cycle by cycle.

// File: rtl/usbdma_pkg.sv
package usbdma_pkg;

    parameter int CNT_W = 16;
    parameter int NFLAG = 3;

    // sticky flag indices
    localparam int FL_EOT = 0;
    localparam int FL_EOB = 1;
    localparam int FL_DLD = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        CH_IDLE  = 3'd0,
        CH_ARM   = 3'd1,
        CH_RUN   = 3'd2,
        CH_DRAIN = 3'd3,
        CH_FETCH = 3'd4
    } ch_state_e;

    typedef struct packed {
        logic en;
        logic ldnext;
        logic closein;
        cnt_t count;
    } ctl_word_t;

    function automatic logic [31:0] pack_status(cnt_t cnt, logic [NFLAG-1:0] fl,
                                                logic act, logic en);
        logic [31:0] r;
        r        = '0;
        r[31:16] = cnt;
        r[6]     = fl[FL_DLD];
        r[5]     = fl[FL_EOB];
        r[4]     = fl[FL_EOT];
        r[1]     = act;
        r[0]     = en;
        return r;
    endfunction

endpackage

// File: rtl/usbdma_fifo.sv
module usbdma_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wptr, rptr;

    assign empty = (wptr == rptr);
    assign full  = (wptr[AW-1:0] == rptr[AW-1:0]) && (wptr[AW] != rptr[AW]);
    assign dout  = mem[rptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push && !full) begin
                mem[wptr[AW-1:0]] <= din;
                wptr <= wptr + 1'b1;
            end
            if (pop && !empty)
                rptr <= rptr + 1'b1;
        end
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R10
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/usbdma_flags.sv
module usbdma_flags
    import usbdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] ev,
    input  logic             rd,
    output logic [NFLAG-1:0] flags
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (ev[i])
                flags[i] <= 1'b1;
            else if (rd)
                flags[i] <= 1'b0;
        end

        // R7
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            ev[i] |=> flags[i]);

        // R7
        rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (rd && !ev[i]) |=> !flags[i]);
    end

endmodule

// File: rtl/usbdma_ctrl.sv
module usbdma_ctrl
    import usbdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  ctl_word_t        ctl,
    input  logic             ep_req,
    input  logic             ep_end,
    input  logic             fifo_full,
    input  logic             fifo_empty,
    input  logic             desc_done,
    input  cnt_t             desc_count,
    output logic             ep_ack,
    output logic             desc_req,
    output logic             en_stat,
    output logic             act_stat,
    output cnt_t             cnt,
    output logic [NFLAG-1:0] ev
);
    ch_state_e st, st_nx;
    logic      ldnext_q, closein_q, zero_end_q;
    logic      sw_on, sw_off, fire, last, end_usb, run_stop;

    assign sw_on    = ctl_wr && ctl.en;
    assign sw_off   = ctl_wr && !ctl.en;
    assign fire     = (st == CH_RUN) && ep_req && !fifo_full && (cnt != '0);
    assign last     = fire && (cnt == CNT_W'(1));
    assign end_usb  = (st == CH_RUN) && ep_end && closein_q;
    assign run_stop = sw_off || last || end_usb || (cnt == '0);

    always_comb begin
        st_nx = st;
        unique case (st)
            CH_IDLE:  if (sw_on) st_nx = CH_ARM;
            CH_ARM:   st_nx = sw_off ? CH_IDLE : CH_RUN;
            CH_RUN:   if (run_stop) st_nx = CH_DRAIN;
            CH_DRAIN: if (fifo_empty)
                          st_nx = (zero_end_q && ldnext_q && !sw_off) ? CH_FETCH : CH_IDLE;
            CH_FETCH: if (sw_off) st_nx = CH_IDLE;
                      else if (desc_done) st_nx = CH_RUN;
            default:  st_nx = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= CH_IDLE;
            cnt        <= '0;
            ldnext_q   <= 1'b0;
            closein_q  <= 1'b0;
            zero_end_q <= 1'b0;
        end else begin
            st <= st_nx;
            if (ctl_wr) begin
                ldnext_q  <= ctl.ldnext;
                closein_q <= ctl.closein;
            end
            if (st == CH_IDLE && sw_on)
                cnt <= ctl.count;
            else if (st == CH_FETCH && desc_done && !sw_off)
                cnt <= desc_count;
            else if (fire)
                cnt <= cnt - CNT_W'(1);
            if (st == CH_RUN && run_stop)
                zero_end_q <= last && !sw_off && !end_usb;
            else if (st == CH_ARM || st == CH_FETCH)
                zero_end_q <= 1'b0;
        end
    end

    assign ep_ack   = fire;
    assign desc_req = (st == CH_FETCH);
    assign en_stat  = (st == CH_RUN) || (st == CH_DRAIN);
    assign act_stat = (st == CH_RUN) && ep_req && (cnt != '0);

    always_comb begin
        ev         = '0;
        ev[FL_EOT] = end_usb;
        ev[FL_EOB] = last;
        ev[FL_DLD] = (st == CH_FETCH) && desc_done && !sw_off;
    end

    // R2
    en_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(en_stat) |-> ($past(st) == CH_ARM) || ($past(st) == CH_FETCH));

    // R3
    cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
        ep_ack |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R4
    zero_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0) |-> !ep_ack);

    // R6
    en_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(en_stat) |-> $past(fifo_empty));

    // R9
    act_chk: assert property (@(posedge clk) disable iff (rst)
        act_stat |-> (en_stat && ep_req && !desc_req));

endmodule

// File: rtl/usbdma_chan.sv
module usbdma_chan
    import usbdma_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic              ctl_en,
    input  logic              ctl_ldnext,
    input  logic              ctl_closein,
    input  logic [15:0]       ctl_count,
    input  logic              stat_rd,
    output logic [31:0]       stat_rdata,
    input  logic              ep_req,
    input  logic [DATA_W-1:0] ep_data,
    input  logic              ep_end,
    output logic              ep_ack,
    output logic              bus_req,
    output logic [DATA_W-1:0] bus_data,
    input  logic              bus_ack,
    output logic              desc_req,
    input  logic              desc_done,
    input  logic [15:0]       desc_count
);
    ctl_word_t        ctl;
    logic             fifo_full, fifo_empty, en_stat, act_stat;
    cnt_t             cnt;
    logic [NFLAG-1:0] ev, flags;

    assign ctl = '{en: ctl_en, ldnext: ctl_ldnext, closein: ctl_closein, count: ctl_count};

    usbdma_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ctl_wr     (ctl_wr),
        .ctl        (ctl),
        .ep_req     (ep_req),
        .ep_end     (ep_end),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .desc_done  (desc_done),
        .desc_count (desc_count),
        .ep_ack     (ep_ack),
        .desc_req   (desc_req),
        .en_stat    (en_stat),
        .act_stat   (act_stat),
        .cnt        (cnt),
        .ev         (ev)
    );

    usbdma_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (ep_ack),
        .din   (ep_data),
        .pop   (bus_req && bus_ack),
        .dout  (bus_data),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    usbdma_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .rd    (stat_rd),
        .flags (flags)
    );

    assign bus_req    = !fifo_empty;
    assign stat_rdata = pack_status(cnt, flags, act_stat, en_stat);

    // R6
    drain_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_stat && !desc_req) |-> !ep_ack);

endmodule

// File: tb/usbdma_chan_bench.sv
module usbdma_chan_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 0, ctl_en = 0, ctl_ldnext = 0, ctl_closein = 0;
    logic [15:0] ctl_count = '0;
    logic        stat_rd = 0;
    logic [31:0] stat_rdata;
    logic        ep_req = 0, ep_end = 0, ep_ack;
    logic [7:0]  ep_data = '0;
    logic        bus_req, bus_ack = 0;
    logic [7:0]  bus_data;
    logic        desc_req, desc_done = 0;
    logic [15:0] desc_count = '0;

    int errors = 0;
    int checks = 0;
    int n_push, n_pop;
    logic [7:0] got [16];

    always #5 clk = ~clk;

    usbdma_chan #(.DATA_W(8), .FIFO_DEPTH(2)) u_usbdma_chan (
        .clk(clk), .rst(rst),
        .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_ldnext(ctl_ldnext),
        .ctl_closein(ctl_closein), .ctl_count(ctl_count),
        .stat_rd(stat_rd), .stat_rdata(stat_rdata),
        .ep_req(ep_req), .ep_data(ep_data), .ep_end(ep_end), .ep_ack(ep_ack),
        .bus_req(bus_req), .bus_data(bus_data), .bus_ack(bus_ack),
        .desc_req(desc_req), .desc_done(desc_done), .desc_count(desc_count)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; ctl_wr = 0; stat_rd = 0; ep_req = 0; ep_end = 0;
        bus_ack = 0; desc_done = 0; ep_data = 8'hA0;
        step(); step();
        rst = 1'b0;
        n_push = 0; n_pop = 0;
        #1;
    endtask

    task automatic ctl_write(logic en, logic ldn, logic cin, logic [15:0] c);
        ctl_en = en; ctl_ldnext = ldn; ctl_closein = cin; ctl_count = c;
        ctl_wr = 1'b1;
        step();
        ctl_wr = 1'b0;
        #1;
    endtask

    // one cycle of endpoint and bus traffic with bookkeeping
    task automatic pump_cycle();
        logic pushed;
        pushed = ep_ack;
        if (bus_req && bus_ack) begin
            got[n_pop] = bus_data;
            n_pop++;
        end
        step();
        if (pushed) n_push++;
        ep_data = 8'hA0 + n_push[7:0];
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 status after reset", stat_rdata, 32'h0);
        chk("R1 bus_req after reset", {31'b0, bus_req}, 32'h0);
        chk("R1 desc_req after reset", {31'b0, desc_req}, 32'h0);
        chk("R1 ep_ack after reset", {31'b0, ep_ack}, 32'h0);
    endtask

    task automatic t_basic();
        do_reset();
        ctl_write(1'b1, 1'b0, 1'b0, 16'd3);
        chk("R2 enable not yet visible", {31'b0, stat_rdata[0]}, 32'h0);
        step();
        chk("R2 enable visible", {31'b0, stat_rdata[0]}, 32'h1);
        chk("R3 count and zero bits", stat_rdata, 32'h0003_0001);
        ep_req = 1'b1; #1;
        pump_cycle();
        chk("R3 count after one byte", {16'b0, stat_rdata[31:16]}, 32'd2);
        pump_cycle();
        chk("R10 ep_ack low when FIFO full", {31'b0, ep_ack}, 32'h0);
        chk("R3 count after two bytes", {16'b0, stat_rdata[31:16]}, 32'd1);
        bus_ack = 1'b1; #1;
        for (int i = 0; i < 10; i++) pump_cycle();
        chk("R4 bytes accepted", n_push, 32'd3);
        chk("R10 bytes delivered", n_pop, 32'd3);
        chk("R10 order byte0", {24'b0, got[0]}, 32'hA0);
        chk("R10 order byte1", {24'b0, got[1]}, 32'hA1);
        chk("R10 order byte2", {24'b0, got[2]}, 32'hA2);
        chk("R4 end-of-buffer flag", {31'b0, stat_rdata[5]}, 32'h1);
        chk("R4 enabled cleared", {31'b0, stat_rdata[0]}, 32'h0);
        chk("R4 count zero", {16'b0, stat_rdata[31:16]}, 32'h0);
        ep_req = 1'b0;
        stat_rd = 1'b1; #1;
        chk("R7 flag visible on read", {31'b0, stat_rdata[5]}, 32'h1);
        step();
        stat_rd = 1'b0; #1;
        chk("R7 flag cleared by read", {31'b0, stat_rdata[5]}, 32'h0);
    endtask

    task automatic t_usb_end();
        do_reset();
        ctl_write(1'b1, 1'b0, 1'b0, 16'd5);
        step();
        ep_end = 1'b1;
        step();
        ep_end = 1'b0; #1;
        chk("R5 ep_end ignored: enabled", {31'b0, stat_rdata[0]}, 32'h1);
        chk("R5 ep_end ignored: flag", {31'b0, stat_rdata[4]}, 32'h0);
        chk("R5 ep_end ignored: count", {16'b0, stat_rdata[31:16]}, 32'd5);
        ctl_write(1'b1, 1'b0, 1'b1, 16'd0);
        ep_end = 1'b1; stat_rd = 1'b1; #1;
        chk("R7 flag clear before event", {31'b0, stat_rdata[4]}, 32'h0);
        step();
        ep_end = 1'b0; stat_rd = 1'b0; #1;
        chk("R7 set wins over read", {31'b0, stat_rdata[4]}, 32'h1);
        step();
        chk("R5 transfer closed", {31'b0, stat_rdata[0]}, 32'h0);
        chk("R5 count kept", {16'b0, stat_rdata[31:16]}, 32'd5);
    endtask

    task automatic t_disable();
        bit dropped;
        do_reset();
        ctl_write(1'b1, 1'b0, 1'b0, 16'd10);
        step();
        ep_req = 1'b1; #1;
        pump_cycle();
        pump_cycle();
        ctl_en = 1'b0; ctl_wr = 1'b1;
        step();
        ctl_wr = 1'b0; #1;
        chk("R6 ep_ack stops on disable", {31'b0, ep_ack}, 32'h0);
        chk("R6 enabled held while FIFO busy", {31'b0, stat_rdata[0]}, 32'h1);
        chk("R3 count frozen after disable", {16'b0, stat_rdata[31:16]}, 32'd8);
        step(); step();
        chk("R6 enabled held without bus ack", {31'b0, stat_rdata[0]}, 32'h1);
        bus_ack = 1'b1; #1;
        dropped = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (stat_rdata[0] == 1'b0) begin
                dropped = 1'b1;
                break;
            end
            pump_cycle();
        end
        chk("R6 enabled dropped", {31'b0, dropped}, 32'h1);
        chk("R6 FIFO empty at drop", {31'b0, bus_req}, 32'h0);
        chk("R6 drained bytes", n_pop, 32'd2);
        chk("R10 drained order", {got[0], got[1]}, {16'b0, 16'hA0A1});
        ep_req = 1'b0;
    endtask

    task automatic t_descriptor();
        do_reset();
        ctl_write(1'b1, 1'b1, 1'b0, 16'd2);
        step();
        chk("R9 inactive without ep_req", {31'b0, stat_rdata[1]}, 32'h0);
        ep_req = 1'b1; #1;
        chk("R9 active when running", {31'b0, stat_rdata[1]}, 32'h1);
        bus_ack = 1'b1; #1;
        for (int i = 0; i < 12; i++) begin
            if (desc_req) break;
            pump_cycle();
        end
        chk("R8 descriptor requested", {31'b0, desc_req}, 32'h1);
        chk("R8 bytes before fetch", n_push, 32'd2);
        chk("R9 inactive while fetching", {31'b0, stat_rdata[1]}, 32'h0);
        chk("R8 disabled while fetching", {31'b0, stat_rdata[0]}, 32'h0);
        chk("R4 end-of-buffer before fetch", {31'b0, stat_rdata[5]}, 32'h1);
        desc_count = 16'd7; desc_done = 1'b1;
        step();
        desc_done = 1'b0; #1;
        chk("R8 enabled after load", {31'b0, stat_rdata[0]}, 32'h1);
        chk("R8 descriptor-loaded flag", {31'b0, stat_rdata[6]}, 32'h1);
        chk("R8 count reloaded", {16'b0, stat_rdata[31:16]}, 32'd7);
        chk("R9 active after load", {31'b0, stat_rdata[1]}, 32'h1);
        chk("R8 request dropped", {31'b0, desc_req}, 32'h0);
        ep_req = 1'b0; stat_rd = 1'b1;
        step();
        stat_rd = 1'b0; #1;
        chk("R7 loaded flag cleared", {31'b0, stat_rdata[6]}, 32'h0);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_usb_end();
        t_disable();
        t_descriptor();
        report();
        $finish;
    end

endmodule